// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting channel of a programmable interval timer. It has a counting clock, a gate input and one output pin. Software programs it through a byte-wide port that has two addresses. The control address takes command words. The data address takes the initial count and returns the current or latched count, one byte per access. Six counting modes are supported: interrupt on terminal count, a retriggerable one-shot, a rate generator, a square wave generator, and a software-triggered or gate-triggered single strobe. Counting runs in plain binary or in four-digit BCD.

The counting clock arrives as a one-cycle enable, `cnt_tick`, on the system clock. Every decrement, reload and change of the output happens on a cycle where `cnt_tick` is high. The only exception is the gate forcing the output high in the periodic modes, which acts on the next system clock. A rising gate edge is caught on any system clock and handled on the next tick. Several channels can share one control address: each instance answers only to its own select code, given by `CHAN_ID`. A 32-bit cascade is made outside the block by feeding one channel's output into the next channel's tick.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is high, no latch is pending, and a status read-back returns 0xC0: output bit 7 set, null-count bit 6 set, and bits 5:0 zero.
- R2: A control-address byte is decoded as follows. Bits 7:6 select the channel, and 11 means read-back. Bits 5:4 give the access type: 00 latch, 01 low byte only, 10 high byte only, 11 low then high. Bits 3:1 give the mode, and 11x is read as mode 2 or 3. Bit 0 selects BCD. A word whose select code names another channel changes nothing in this one.
- R3: Count writes and reads follow the programmed access type. Low-only clears the high byte of the count and high-only clears the low byte. The low-then-high type takes or returns two bytes in that order.
- R4: Mode 0: the output goes low when the mode is programmed and when a count is written. The count loads on the next tick, and the output goes high N ticks after the load. Counting continues past zero and is held while the gate is low. In the two-byte order, writing the first byte freezes the count until the second byte arrives.
- R5: Mode 1: a gate rising edge loads the count on the next tick and drives the output low for N ticks. A new edge restarts the count. A count written between edges takes effect only at the next edge.
- R6: Mode 2: the output is low for one tick in every N. A low gate forces the output high on the next clock and stops counting. A gate rising edge reloads the count.
- R7: Mode 3: the output is a square wave with period N. For odd N it stays high for (N+1)/2 ticks and low for (N-1)/2 ticks. The gate works as in mode 2.
- R8: Mode 4: the count loads on the tick after it is written. The output pulses low for exactly one tick when the count reaches zero, and only once per loaded count. A low gate holds the count.
- R9: Mode 5: a gate rising edge loads the count. The output then pulses low for one tick when the count reaches zero, whatever the gate level.
- R10: With BCD selected, each of the four digits stays in 0 to 9 while counting, and a decrement borrows from the next digit.
- R11: A latch command freezes a copy of the count. Data reads return that copy until it has been fully read in the programmed byte order, and after that they return the live count.
- R12: A read-back command acts on this channel when bit 1+CHAN_ID is set. Bit 5 low latches the count and bit 4 low latches the status byte. The status byte is {output, null count, access type, mode number, BCD}. When both are pending, the status byte is read first.
- R13: Null count is set by programming the mode and by each complete count write. It clears when the written count is moved into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; advances the read sequence |
| bus_ctl | input | 1 | 1 selects the control address, 0 the data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the data address |
| cnt_tick | input | 1 | One-cycle counting-clock enable |
| cnt_gate | input | 1 | Gate input |
| cnt_out | output | 1 | Counter output |

## Verification
Most faults in the counting element or the reload path show up on `cnt_out` within one output period. A wrong reload or a wrong step size moves an edge by at least one tick, and the bench samples every tick of each pattern. Faults in the read path show up on the next data read. A read sequencer stuck in the wrong phase swaps the bytes. A latch that never releases returns a stale count on the read after the first full read. A status latch that does not clear returns the status byte where a count byte was expected. The bench places these reads right after the stimulus, so a fault appears within a few accesses.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_PAIR  = 2'b11
    } acc_e;

    typedef enum logic [2:0] {
        M_TC_INT    = 3'd0,
        M_ONESHOT   = 3'd1,
        M_RATE      = 3'd2,
        M_SQUARE    = 3'd3,
        M_SW_STROBE = 3'd4,
        M_HW_STROBE = 3'd5
    } mode_e;

    typedef struct packed {
        acc_e  acc;
        mode_e mode;
        logic  bcd;
    } cfg_t;

endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode
    import pit_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic       bus_wr,
    input  logic       bus_ctl,
    input  logic [7:0] bus_wdata,
    output logic       prog_en,
    output cfg_t       prog_cfg,
    output logic       latch_cnt,
    output logic       latch_sts,
    output logic       data_wr
);
    localparam logic [1:0] SEL_ME = 2'(CHAN_ID);
    localparam logic [1:0] SEL_RB = 2'b11;
    localparam int         RB_BIT = 1 + CHAN_ID;

    logic ctl_wr, mine, rb_hit, acc_zero;

    always_comb begin
        ctl_wr   = bus_wr && bus_ctl;
        mine     = ctl_wr && (bus_wdata[7:6] == SEL_ME);
        rb_hit   = ctl_wr && (bus_wdata[7:6] == SEL_RB) && bus_wdata[RB_BIT];
        acc_zero = (bus_wdata[5:4] == 2'b00);

        prog_en  = mine && !acc_zero;
        prog_cfg.acc  = acc_e'(bus_wdata[5:4]);
        prog_cfg.mode = bus_wdata[2] ? mode_e'({1'b0, 1'b1, bus_wdata[1]})
                                     : mode_e'(bus_wdata[3:1]);
        prog_cfg.bcd  = bus_wdata[0];

        latch_cnt = (mine && acc_zero) || (rb_hit && !bus_wdata[5]);
        latch_sts = rb_hit && !bus_wdata[4];
        data_wr   = bus_wr && !bus_ctl;
    end

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             prog_en,
    input  cfg_t             prog_cfg,
    input  logic             data_wr,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             out_o,
    output logic             null_o,
    output cfg_t             cfg_o
);
    localparam int NDIG = CNT_W / 4;

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] ce;
        logic [CNT_W-1:0] cr;
        logic             out;
        logic             nullc;
        logic             gate_s;
        logic             trig;
        logic             load_pend;
        logic             running;
        logic             halt;
        logic             fresh;
        logic             armed;
        logic             wff;
    } core_t;

    core_t s_q, s_d;

    function automatic logic [CNT_W-1:0] sub_cnt(input logic [CNT_W-1:0] v,
                                                 input logic [1:0] k,
                                                 input logic bcd);
        logic [CNT_W-1:0] r;
        logic [1:0]       brw;
        logic [4:0]       t;
        if (!bcd) begin
            r = v - CNT_W'(k);
        end else begin
            r   = v;
            brw = k;
            for (int i = 0; i < NDIG; i++) begin
                t = {1'b0, v[i*4 +: 4]} - {3'b000, brw};
                if (t[4]) begin
                    t   = t + 5'd10;
                    brw = 2'd1;
                end else begin
                    brw = 2'd0;
                end
                r[i*4 +: 4] = t[3:0];
            end
        end
        return r;
    endfunction

    logic [CNT_W-1:0] dec1, sq_next;
    logic [1:0]       step;
    logic             done, is_per, is_strobe;

    always_comb begin
        s_d       = s_q;
        dec1      = sub_cnt(s_q.ce, 2'd1, s_q.cfg.bcd);
        step      = (s_q.fresh && s_q.cr[0]) ? (s_q.out ? 2'd1 : 2'd3) : 2'd2;
        sq_next   = sub_cnt(s_q.ce, step, s_q.cfg.bcd);
        done      = 1'b0;
        is_per    = (s_q.cfg.mode == M_RATE) || (s_q.cfg.mode == M_SQUARE);
        is_strobe = (s_q.cfg.mode == M_SW_STROBE) || (s_q.cfg.mode == M_HW_STROBE);

        s_d.gate_s = gate_i;
        if (gate_i && !s_q.gate_s) s_d.trig = 1'b1;

        if (data_wr) begin
            case (s_q.cfg.acc)
                ACC_LO: begin s_d.cr = CNT_W'(wdata); done = 1'b1; end
                ACC_HI: begin s_d.cr = CNT_W'({wdata, 8'h00}); done = 1'b1; end
                ACC_PAIR: begin
                    if (!s_q.wff) begin
                        s_d.cr[7:0] = wdata;
                        s_d.wff     = 1'b1;
                        if (s_q.cfg.mode == M_TC_INT) s_d.halt = 1'b1;
                    end else begin
                        s_d.cr[CNT_W-1 -: 8] = wdata;
                        s_d.wff = 1'b0;
                        done    = 1'b1;
                    end
                end
                default: ;
            endcase
            if (done) begin
                s_d.nullc = 1'b1;
                s_d.halt  = 1'b0;
                if (s_q.cfg.mode == M_TC_INT) s_d.out = 1'b0;
                if (s_q.cfg.mode == M_TC_INT || s_q.cfg.mode == M_SW_STROBE ||
                    (is_per && !s_q.running))
                    s_d.load_pend = 1'b1;
            end
        end

        if (tick_i) begin
            if (is_strobe) s_d.out = 1'b1;
            case (s_q.cfg.mode)
                M_TC_INT: begin
                    if (s_q.load_pend) begin
                        s_d.ce = s_q.cr; s_d.load_pend = 1'b0;
                        s_d.nullc = 1'b0; s_d.running = 1'b1;
                    end else if (s_q.running && gate_i && !s_q.halt) begin
                        s_d.ce = dec1;
                        if (dec1 == '0) s_d.out = 1'b1;
                    end
                end
                M_ONESHOT, M_HW_STROBE: begin
                    if (s_q.trig) begin
                        s_d.ce = s_q.cr; s_d.trig = 1'b0; s_d.nullc = 1'b0;
                        s_d.running = 1'b1; s_d.armed = 1'b1;
                        s_d.out = (s_q.cfg.mode == M_HW_STROBE);
                    end else if (s_q.running) begin
                        s_d.ce = dec1;
                        if (dec1 == '0) begin
                            s_d.out   = (s_q.cfg.mode == M_ONESHOT) || !s_q.armed;
                            s_d.armed = 1'b0;
                        end
                    end
                end
                M_RATE, M_SQUARE: begin
                    if ((s_q.load_pend || s_q.trig) && gate_i) begin
                        s_d.ce = s_q.cr; s_d.load_pend = 1'b0; s_d.trig = 1'b0;
                        s_d.nullc = 1'b0; s_d.out = 1'b1;
                        s_d.running = 1'b1; s_d.fresh = 1'b1;
                    end else if (s_q.running && gate_i) begin
                        if (s_q.cfg.mode == M_RATE) begin
                            if (s_q.ce == CNT_W'(1)) begin
                                s_d.ce = s_q.cr; s_d.nullc = 1'b0; s_d.out = 1'b1;
                            end else begin
                                s_d.ce  = dec1;
                                s_d.out = (dec1 != CNT_W'(1));
                            end
                        end else if (s_q.ce == CNT_W'(step)) begin
                            s_d.out = !s_q.out; s_d.ce = s_q.cr;
                            s_d.nullc = 1'b0; s_d.fresh = 1'b1;
                        end else begin
                            s_d.ce = sq_next; s_d.fresh = 1'b0;
                        end
                    end
                end
                M_SW_STROBE: begin
                    if (s_q.load_pend) begin
                        s_d.ce = s_q.cr; s_d.load_pend = 1'b0; s_d.nullc = 1'b0;
                        s_d.running = 1'b1; s_d.armed = 1'b1;
                    end else if (s_q.running && gate_i) begin
                        s_d.ce = dec1;
                        if (s_q.armed && dec1 == '0) begin
                            s_d.out = 1'b0; s_d.armed = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (is_per && !gate_i) s_d.out = 1'b1;

        if (prog_en) begin
            s_d.cfg       = prog_cfg;
            s_d.out       = (prog_cfg.mode != M_TC_INT);
            s_d.nullc     = 1'b1;
            s_d.load_pend = 1'b0;
            s_d.running   = 1'b0;
            s_d.halt      = 1'b0;
            s_d.trig      = 1'b0;
            s_d.wff       = 1'b0;
            s_d.armed     = 1'b0;
            s_d.fresh     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.out   <= 1'b1;
            s_q.nullc <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o  = s_q.ce;
    assign out_o  = s_q.out;
    assign null_o = s_q.nullc;
    assign cfg_o  = s_q.cfg;

    // R4: programming mode 0 drives the output low
    p_mode0_prog_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en && (prog_cfg.mode == M_TC_INT) |=> !out_o);

    // R6 / R7: a low gate in a periodic mode forces the output high
    p_gate_forces_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cfg.mode == M_RATE || s_q.cfg.mode == M_SQUARE) && !gate_i && !prog_en
        |=> out_o);

    // R8 / R9: a strobe lasts a single tick
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cfg.mode == M_SW_STROBE || s_q.cfg.mode == M_HW_STROBE) &&
        !out_o && tick_i && !prog_en |=> out_o);

endmodule

// File: rtl/pit_readout.sv
module pit_readout
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             latch_cnt_i,
    input  logic             latch_sts_i,
    input  logic             rd_i,
    input  acc_e             acc_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [7:0]       sts_i,
    output logic [7:0]       rdata_o
);
    typedef struct packed {
        logic [CNT_W-1:0] ol;
        logic             ol_v;
        logic [7:0]       st;
        logic             st_v;
        logic             rff;
    } rd_t;

    rd_t r_q, r_d;
    logic [CNT_W-1:0] src;

    always_comb begin
        src = r_q.ol_v ? r_q.ol : cnt_i;
        if (r_q.st_v)                                rdata_o = r_q.st;
        else if (acc_i == ACC_HI)                    rdata_o = src[CNT_W-1 -: 8];
        else if (acc_i == ACC_PAIR && r_q.rff)       rdata_o = src[CNT_W-1 -: 8];
        else                                         rdata_o = src[7:0];

        r_d = r_q;
        if (rd_i) begin
            if (r_q.st_v) begin
                r_d.st_v = 1'b0;
            end else if (acc_i == ACC_PAIR && !r_q.rff) begin
                r_d.rff = 1'b1;
            end else begin
                r_d.rff  = 1'b0;
                r_d.ol_v = 1'b0;
            end
        end
        if (latch_cnt_i && !r_d.ol_v) begin
            r_d.ol   = cnt_i;
            r_d.ol_v = 1'b1;
        end
        if (latch_sts_i && !r_d.st_v) begin
            r_d.st   = sts_i;
            r_d.st_v = 1'b1;
        end
        if (clear_i) r_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R11: a latched count stays frozen until it is read
    p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ol_v && !rd_i && !clear_i |=> $stable(r_q.ol) && r_q.ol_v);

    // R12: a pending status byte is consumed by one read
    p_status_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st_v && rd_i && !latch_sts_i |=> !r_q.st_v);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CHAN_ID = 0,
    parameter int CNT_W   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_ctl,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cnt_tick,
    input  logic       cnt_gate,
    output logic       cnt_out
);
    logic             prog_en, latch_cnt, latch_sts, data_wr, null_c;
    cfg_t             prog_cfg, cfg;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       sts;

    pit_cmd_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .bus_wr    (bus_wr),
        .bus_ctl   (bus_ctl),
        .bus_wdata (bus_wdata),
        .prog_en   (prog_en),
        .prog_cfg  (prog_cfg),
        .latch_cnt (latch_cnt),
        .latch_sts (latch_sts),
        .data_wr   (data_wr)
    );

    pit_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (cnt_tick),
        .gate_i   (cnt_gate),
        .prog_en  (prog_en),
        .prog_cfg (prog_cfg),
        .data_wr  (data_wr),
        .wdata    (bus_wdata),
        .cnt_o    (cnt),
        .out_o    (cnt_out),
        .null_o   (null_c),
        .cfg_o    (cfg)
    );

    assign sts = {cnt_out, null_c, cfg};

    pit_readout #(.CNT_W(CNT_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (prog_en),
        .latch_cnt_i (latch_cnt),
        .latch_sts_i (latch_sts),
        .rd_i        (bus_rd && !bus_ctl),
        .acc_i       (cfg.acc),
        .cnt_i       (cnt),
        .sts_i       (sts),
        .rdata_o     (bus_rdata)
    );

endmodule

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
    localparam int CLK_P = 10;
    localparam int WD_CYC = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_ctl = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cnt_tick = 1'b0, cnt_gate = 1'b1;
    logic       cnt_out;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pit_channel dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ctl(bus_ctl), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_tick(cnt_tick), .cnt_gate(cnt_gate), .cnt_out(cnt_out)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic ctl, logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_ctl = ctl; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_ctl = 1'b0; #1;
    endtask

    task automatic rd_chk(string req, logic [7:0] exp);
        @(negedge clk); bus_rd = 1'b1; #1;
        chk(req, bus_rdata, exp);
        @(negedge clk); bus_rd = 1'b0; #1;
    endtask

    task automatic tick1();
        @(negedge clk); cnt_tick = 1'b1;
        @(negedge clk); cnt_tick = 1'b0; #1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    // expected output after each tick, one character per tick
    task automatic tick_seq(string req, string pat);
        for (int i = 0; i < pat.len(); i++) begin
            tick1();
            chk(req, {7'd0, cnt_out}, (pat[i] == "1") ? 8'd1 : 8'd0);
        end
    endtask

    task automatic gate(logic v);
        @(negedge clk); cnt_gate = v; #1;
    endtask

    task automatic pulse_gate();
        gate(1'b0); gate(1'b1);
    endtask

    task automatic t_reset();
        chk("R1 out after reset", {7'd0, cnt_out}, 8'd1);
        wr(1'b1, 8'hE2);
        rd_chk("R1 status after reset", 8'hC0);
        rd_chk("R1 no latch pending", 8'h00);
    endtask

    task automatic t_mode0();
        wr(1'b1, 8'h10);
        chk("R4 out low on program", {7'd0, cnt_out}, 8'd0);
        wr(1'b0, 8'd5);
        tick_seq("R4 terminal count N=5", "000001");
        gate(1'b0); ticks(3);
        wr(1'b1, 8'h00);
        rd_chk("R4 gate low holds count", 8'h00);
        gate(1'b1); tick1();
        wr(1'b1, 8'h00);
        rd_chk("R4 counts on past zero", 8'hFF);
        // two-byte order, halt on first byte, null count
        wr(1'b1, 8'h30);
        wr(1'b0, 8'd10); wr(1'b0, 8'd0);
        wr(1'b1, 8'hE2);
        rd_chk("R13 null set after write", 8'h70);
        tick1();
        wr(1'b1, 8'hE2);
        rd_chk("R13 null cleared after load", 8'h30);
        ticks(2);
        wr(1'b0, 8'd4);
        ticks(5);
        wr(1'b1, 8'h00);
        rd_chk("R4 first byte halts (low)", 8'h08);
        rd_chk("R3 pair order high byte", 8'h00);
        wr(1'b0, 8'd0);
        tick_seq("R4 second byte starts new count", "00001");
    endtask

    task automatic t_mode2();
        wr(1'b1, 8'h1C);
        wr(1'b1, 8'hE2);
        rd_chk("R2 mode 11x read as 2", 8'hD4);
        wr(1'b0, 8'd4);
        tick_seq("R6 rate N=4", "11101110");
        gate(1'b0);
        @(negedge clk); #1;
        chk("R6 gate low forces high", {7'd0, cnt_out}, 8'd1);
        tick_seq("R6 gate low stops", "11");
        gate(1'b1);
        tick_seq("R6 gate rise reloads", "1110");
        wr(1'b1, 8'h00);
        tick1();
        rd_chk("R11 latched value held", 8'h01);
        rd_chk("R11 live after latch read", 8'h04);
    endtask

    task automatic t_mode3();
        wr(1'b1, 8'h16);
        wr(1'b0, 8'd5);
        tick_seq("R7 odd N=5 high 3 low 2", "1110011100");
        wr(1'b1, 8'h17);
        wr(1'b0, 8'h10);
        tick_seq("R10 BCD square N=10", "11111000001");
    endtask

    task automatic t_mode4();
        wr(1'b1, 8'h18);
        wr(1'b0, 8'd3);
        tick_seq("R8 single strobe N=3", "111011");
        wr(1'b0, 8'd3);
        gate(1'b0);
        tick_seq("R8 gate low inhibits", "11111");
        wr(1'b1, 8'h00);
        rd_chk("R8 count held by gate", 8'h03);
        gate(1'b1);
        tick_seq("R8 resume after gate", "110");
    endtask

    task automatic t_mode1();
        wr(1'b1, 8'h12);
        wr(1'b0, 8'd3);
        gate(1'b0);
        tick_seq("R5 idle without trigger", "11");
        gate(1'b1);
        tick_seq("R5 one-shot N=3", "0001");
        pulse_gate();
        tick_seq("R5 first two ticks", "00");
        pulse_gate();
        tick_seq("R5 retrigger restarts", "0001");
        wr(1'b0, 8'd2);
        wr(1'b1, 8'hE2);
        rd_chk("R13 null set by write in mode 1", 8'hD2);
        tick_seq("R5 new count waits for trigger", "11");
        pulse_gate();
        tick_seq("R5 new count on next trigger", "001");
    endtask

    task automatic t_mode5();
        wr(1'b1, 8'h1A);
        wr(1'b0, 8'd2);
        tick_seq("R9 waits for gate edge", "11");
        pulse_gate();
        tick_seq("R9 strobe N=2", "1101");
        wr(1'b1, 8'h50);
        chk("R2 other channel ignored", {7'd0, cnt_out}, 8'd1);
        wr(1'b1, 8'hE4);
        rd_chk("R12 read-back for other channel ignored", 8'hFF);
        wr(1'b1, 8'hC2);
        tick1();
        rd_chk("R12 status read first", 8'h9A);
        rd_chk("R12 latched count after status", 8'hFF);
        rd_chk("R11 live count after latch", 8'hFE);
    endtask

    task automatic t_access();
        wr(1'b1, 8'h20);
        wr(1'b0, 8'h01);
        tick1();
        wr(1'b1, 8'h00);
        rd_chk("R3 high-only read", 8'h01);
        wr(1'b1, 8'h30);
        wr(1'b1, 8'h00);
        rd_chk("R3 high-only write cleared low byte", 8'h00);
        rd_chk("R3 high byte in pair", 8'h01);
        wr(1'b1, 8'h10);
        wr(1'b0, 8'h05);
        tick1();
        wr(1'b1, 8'h30);
        wr(1'b1, 8'h00);
        rd_chk("R3 low-only write low byte", 8'h05);
        rd_chk("R3 low-only write cleared high byte", 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_mode0();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode1();
        t_mode5();
        t_access();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule